// File: doc/BRIEF.md
# Sequential SPI SRAM Streaming Controller

This block drives a byte-wide serial SRAM over a four-wire SPI link and moves 16-bit records into or out of it as one continuous burst. A pulse on the write-start or the read-start input opens a burst. The block pulls chip select low and sends the instruction byte. It then sends three zero address bytes, so every burst begins at location zero. After that it streams data bytes until the host asks it to stop. The memory advances its own address after each byte, so no further address traffic is needed.

On a write burst, each record is taken from the host, high byte first, and sent as two bytes. On a read burst, each pair of bytes from the memory is joined into one record and presented with a one-cycle valid pulse. The serial clock is made inside the block from the system clock. Each half-period lasts `CLK_DIV` system cycles. The link runs in mode 0, so the serial clock is low at rest, the block drives on the falling edge, and it samples on the rising edge.

Top module: `sram_stream_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, and rec_slot and rd_valid are 0.
- R2: A start_wr pulse while idle opens a burst whose first byte on mosi is 0x02, followed by three 0x00 address bytes. If start_wr and start_rd are high in the same cycle, the burst is a write.
- R3: A start_rd pulse while idle opens a burst whose first byte is 0x03, followed by three 0x00 address bytes.
- R4: The serial link runs in mode 0 and sends each byte MSB first. sck is 0 whenever cs_n is 1. Each high phase of sck lasts exactly CLK_DIV clock cycles. mosi holds steady while sck is high. miso is sampled at the rising edge of sck.
- R5: On a write burst, wr_rec is sampled at the clock edge that raises the one-cycle rec_slot pulse. The record is sent as wr_rec[15:8] and then wr_rec[7:0], so the memory receives it at two consecutive locations starting at 0.
- R6: On a read burst, each pair of data bytes sets rd_rec = {first byte, second byte} and gives one single-cycle rd_valid pulse. rd_valid never pulses in a write burst.
- R7: stop is sampled when the low byte of a record completes. If stop is 1 there, cs_n goes high and the burst ends. If stop is 0, the next record follows. A burst always carries at least one record.
- R8: busy equals the inverse of cs_n in every cycle.
- R9: start_wr and start_rd are ignored while a burst is open. After the burst ends, no new burst begins unless a new start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr | input | 1 | Open a write burst (pulse) |
| start_rd | input | 1 | Open a read burst (pulse) |
| stop | input | 1 | End the burst after the current record |
| wr_rec | input | 16 | Record to write, sampled when rec_slot rises |
| rec_slot | output | 1 | One-cycle pulse at the start of each record slot |
| rd_rec | output | 16 | Record assembled from memory |
| rd_valid | output | 1 | One-cycle pulse when rd_rec is new |
| busy | output | 1 | High while a burst is open |
| cs_n | output | 1 | Memory chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to memory |
| miso | input | 1 | Serial data from memory |

## Verification
The bench uses a behavioural memory that decodes the instruction and address from the serial line. Byte order is checked with records whose two halves differ, such as 0x8001 and 0xA55A. A design that swapped the halves, or sent LSB first, would leave the wrong bytes at locations zero and one. A one-record burst with stop held high checks that exactly two data bytes are sent. An off-by-one in the stop sampling would send four bytes or none. Other cases cover simultaneous start pulses, which must give a write, and a read-start pulse in the middle of a write, which must neither change the burst nor open a second one. A read-back of the written table catches a design that sampled miso on the wrong edge, because every data bit would then be shifted by one place.

// File: rtl/sram_stream_pkg.sv
`timescale 1ns/1ps
package sram_stream_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_HIB,
    ST_LOB
  } burst_st_t;
endpackage

// File: rtl/spi_mode0_shifter.sv
`timescale 1ns/1ps
module spi_mode0_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       active
);
  localparam int CW = $clog2(CLK_DIV + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic          sck_q, sck_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;
  logic          tick;

  assign tick = act_q && (cnt_q == CNT_LAST);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sck_d  = sck_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (go && !act_q) begin
      act_d = 1'b1;
      cnt_d = '0;
      bit_d = '0;
      sck_d = 1'b0;
      tx_d  = tx_byte;
    end else if (act_q) begin
      if (tick) begin
        cnt_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso};
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sck_q  <= sck_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign active  = act_q;

  // R4: data line holds while the serial clock is high
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(tx_q[7]));

  // R4: the serial clock changes only when a half period has elapsed
  assert_sck_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/sram_burst_seq.sv
`timescale 1ns/1ps
module sram_burst_seq
  import sram_stream_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_wr,
  input  logic        start_rd,
  input  logic        stop,
  input  logic [15:0] wr_rec,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  input  logic        sh_active,
  output logic        sh_go,
  output logic [7:0]  sh_tx,
  output logic        cs_act,
  output logic        rec_slot,
  output logic [15:0] rd_rec,
  output logic        rd_valid
);
  localparam int ACW = $clog2(ADDR_BYTES);
  localparam logic [ACW-1:0] ADR_LAST = ACW'(ADDR_BYTES - 1);

  burst_st_t      st_q, st_d;
  logic           rd_q, rd_d;
  logic [ACW-1:0] acnt_q, acnt_d;
  logic [15:0]    rec_q, rec_d;
  logic [7:0]     hi_q, hi_d;
  logic           go_q, go_d;
  logic [7:0]     tx_q, tx_d;
  logic           cs_q, cs_d;
  logic           slot_q, slot_d;
  logic           rdv_q, rdv_d;
  logic [15:0]    rdr_q, rdr_d;

  always_comb begin
    st_d   = st_q;
    rd_d   = rd_q;
    acnt_d = acnt_q;
    rec_d  = rec_q;
    hi_d   = hi_q;
    tx_d   = tx_q;
    cs_d   = cs_q;
    rdr_d  = rdr_q;
    go_d   = 1'b0;
    slot_d = 1'b0;
    rdv_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_wr || start_rd) begin
        cs_d = 1'b1;
        rd_d = !start_wr;
        go_d = 1'b1;
        tx_d = start_wr ? OP_WRITE : OP_READ;
        st_d = ST_OPC;
      end
      ST_OPC: if (sh_done) begin
        st_d   = ST_ADR;
        acnt_d = '0;
        go_d   = 1'b1;
        tx_d   = 8'h00;
      end
      ST_ADR: if (sh_done) begin
        go_d = 1'b1;
        if (acnt_q == ADR_LAST) begin
          st_d   = ST_HIB;
          slot_d = 1'b1;
          rec_d  = wr_rec;
          tx_d   = rd_q ? 8'h00 : wr_rec[15:8];
        end else begin
          acnt_d = acnt_q + ACW'(1);
          tx_d   = 8'h00;
        end
      end
      ST_HIB: if (sh_done) begin
        hi_d = sh_rx;
        st_d = ST_LOB;
        go_d = 1'b1;
        tx_d = rd_q ? 8'h00 : rec_q[7:0];
      end
      ST_LOB: if (sh_done) begin
        if (rd_q) begin
          rdr_d = {hi_q, sh_rx};
          rdv_d = 1'b1;
        end
        if (stop) begin
          st_d = ST_IDLE;
          cs_d = 1'b0;
        end else begin
          st_d   = ST_HIB;
          go_d   = 1'b1;
          slot_d = 1'b1;
          rec_d  = wr_rec;
          tx_d   = rd_q ? 8'h00 : wr_rec[15:8];
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      acnt_q <= '0;
      rec_q  <= '0;
      hi_q   <= '0;
      go_q   <= 1'b0;
      tx_q   <= '0;
      cs_q   <= 1'b0;
      slot_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdr_q  <= '0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      acnt_q <= acnt_d;
      rec_q  <= rec_d;
      hi_q   <= hi_d;
      go_q   <= go_d;
      tx_q   <= tx_d;
      cs_q   <= cs_d;
      slot_q <= slot_d;
      rdv_q  <= rdv_d;
      rdr_q  <= rdr_d;
    end
  end

  assign sh_go    = go_q;
  assign sh_tx    = tx_q;
  assign cs_act   = cs_q;
  assign rec_slot = slot_q;
  assign rd_rec   = rdr_q;
  assign rd_valid = rdv_q;

  // R2: a byte launch is only issued to an idle shifter
  assert_launch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> !sh_active);

  // R7: the burst closes only at a completed low byte with stop high
  assert_close_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> $past(st_q == ST_LOB && sh_done && stop));

  // R6: read records appear only in read bursts
  assert_rdv_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> rd_q);

  // R9: the direction of an open burst does not change
  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> $stable(rd_q));
endmodule

// File: rtl/sram_stream_ctrl.sv
`timescale 1ns/1ps
module sram_stream_ctrl #(
  parameter int CLK_DIV    = 2,
  parameter int ADDR_BYTES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_wr,
  input  logic        start_rd,
  input  logic        stop,
  input  logic [15:0] wr_rec,
  output logic        rec_slot,
  output logic [15:0] rd_rec,
  output logic        rd_valid,
  output logic        busy,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  logic       sh_go;
  logic [7:0] sh_tx;
  logic       sh_done;
  logic [7:0] sh_rx;
  logic       sh_active;
  logic       cs_act;

  sram_burst_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .stop     (stop),
    .wr_rec   (wr_rec),
    .sh_done  (sh_done),
    .sh_rx    (sh_rx),
    .sh_active(sh_active),
    .sh_go    (sh_go),
    .sh_tx    (sh_tx),
    .cs_act   (cs_act),
    .rec_slot (rec_slot),
    .rd_rec   (rd_rec),
    .rd_valid (rd_valid)
  );

  spi_mode0_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (sh_go),
    .tx_byte(sh_tx),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .done   (sh_done),
    .rx_byte(sh_rx),
    .active (sh_active)
  );

  assign cs_n = !cs_act;
  assign busy = cs_act;

  // R4: serial clock stays low whenever the memory is deselected
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !sck);
endmodule

// File: tb/sim_sram_stream_ctrl.sv
`timescale 1ns/1ps
module sim_sram_stream_ctrl;
  localparam int DIV  = 2;
  localparam int NREC = 8;
  localparam logic [15:0] TBL [NREC] = '{
    16'h8001, 16'hA55A, 16'h0000, 16'hFFFF,
    16'h1234, 16'hC3E1, 16'h7F80, 16'h0102
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 1'b0, start_rd = 1'b0, stop = 1'b0;
  logic [15:0] wr_rec = '0;
  logic rec_slot, rd_valid, busy, cs_n, sck, mosi;
  logic miso = 1'b0;
  logic [15:0] rd_rec;

  always #2.5 clk = ~clk;

  sram_stream_ctrl #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .stop(stop), .wr_rec(wr_rec), .rec_slot(rec_slot), .rd_rec(rd_rec),
    .rd_valid(rd_valid), .busy(busy), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural serial memory
  logic [7:0] mem_b [64];
  int   nbits = 0;
  logic [7:0] sh = '0;
  logic [7:0] cap_cmd = '0;
  logic [23:0] cap_adr = '0;
  int   dbytes = 0;

  always @(negedge cs_n) begin
    nbits = 0; dbytes = 0; cap_adr = '0;
  end

  always @(posedge sck) begin
    sh = {sh[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      if (nbits == 8) cap_cmd = sh;
      else if (nbits <= 32) cap_adr = {cap_adr[15:0], sh};
      else begin
        if (cap_cmd == 8'h02) mem_b[((nbits / 8) - 5) % 64] = sh;
        dbytes = (nbits / 8) - 4;
      end
    end
  end

  always @(negedge sck) begin
    if (cap_cmd == 8'h03 && nbits >= 32)
      miso = mem_b[((nbits - 32) / 8) % 64][7 - ((nbits - 32) % 8)];
  end

  // link watchers: R4 and R8
  int hi_run = 0, bad_half = 0, bad_mosi = 0, bad_busy = 0, bad_idle = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy != !cs_n) bad_busy++;
      if (cs_n && sck) bad_idle++;
      if (sck && prev_sck && mosi != prev_mosi) bad_mosi++;
      if (sck) hi_run++;
      else if (hi_run > 0) begin
        if (hi_run != DIV) bad_half++;
        hi_run = 0;
      end
    end
    prev_sck = sck;
    prev_mosi = mosi;
  end

  int rd_got = 0, rd_bad = 0, wr_valid_seen = 0;

  // one burst walking the record table; poke_rd injects a read start mid-burst
  task automatic burst(input bit rd, input bit both, input int n, input bit poke_rd);
    int slots = 0;
    int cyc = 0;
    rd_got = 0; rd_bad = 0; wr_valid_seen = 0;
    @(negedge clk);
    stop = 1'b0;
    wr_rec = TBL[0];
    start_wr = !rd || both;
    start_rd = rd || both;
    @(negedge clk);
    start_wr = 1'b0; start_rd = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      start_rd = poke_rd && (cyc == 60);
      if (rec_slot) begin
        slots++;
        wr_rec = (slots < NREC) ? TBL[slots] : 16'h0;
        if (slots >= n) stop = 1'b1;
      end
      if (rd_valid) begin
        if (!rd) wr_valid_seen++;
        else begin
          if (rd_rec != TBL[rd_got % NREC]) begin
            rd_bad++;
            $display("FAIL R6: record %0d got %0h expected %0h",
                     rd_got, rd_rec, TBL[rd_got % NREC]);
          end
          rd_got++;
        end
      end
    end while (!cs_n);
    start_rd = 1'b0;
    stop = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_b[i] = 8'h00;
    #1;
    chk(cs_n === 1'b1, "R1 cs_n in reset", cs_n, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
    chk(sck === 1'b0, "R1 sck", sck, 0);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(rec_slot === 1'b0 && rd_valid === 1'b0, "R1 pulses", {rec_slot, rd_valid}, 0);

    // full write burst of the table
    burst(1'b0, 1'b0, NREC, 1'b0);
    chk(cap_cmd == 8'h02, "R2 write opcode", cap_cmd, 8'h02);
    chk(cap_adr == 24'h0, "R2 address", cap_adr, 0);
    chk(dbytes == 2 * NREC, "R7 write byte count", dbytes, 2 * NREC);
    chk(wr_valid_seen == 0, "R6 no rd_valid on write", wr_valid_seen, 0);
    for (int k = 0; k < NREC; k++) begin
      chk(mem_b[2*k] == TBL[k][15:8], "R5 high byte", mem_b[2*k], TBL[k][15:8]);
      chk(mem_b[2*k+1] == TBL[k][7:0], "R5 low byte", mem_b[2*k+1], TBL[k][7:0]);
    end

    // read it back
    burst(1'b1, 1'b0, NREC, 1'b0);
    chk(cap_cmd == 8'h03, "R3 read opcode", cap_cmd, 8'h03);
    chk(cap_adr == 24'h0, "R3 address", cap_adr, 0);
    chk(rd_got == NREC, "R6 record count", rd_got, NREC);
    chk(rd_bad == 0, "R6 record values", rd_bad, 0);

    // single record, stop held from the start
    mem_b[2] = 8'h5A; mem_b[3] = 8'h5A;
    burst(1'b0, 1'b0, 1, 1'b0);
    chk(dbytes == 2, "R7 single record bytes", dbytes, 2);
    chk(mem_b[2] == 8'h5A, "R7 no extra byte", mem_b[2], 8'h5A);

    // both starts together: write wins
    burst(1'b0, 1'b1, 1, 1'b0);
    chk(cap_cmd == 8'h02, "R2 start priority", cap_cmd, 8'h02);
    chk(dbytes == 2, "R2 priority bytes", dbytes, 2);

    // read start pulse inside a write burst is ignored
    burst(1'b0, 1'b0, 2, 1'b1);
    chk(cap_cmd == 8'h02, "R9 opcode kept", cap_cmd, 8'h02);
    chk(dbytes == 4, "R9 byte count", dbytes, 4);
    begin
      int low_seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (!cs_n) low_seen++;
      end
      chk(low_seen == 0, "R9 no new burst", low_seen, 0);
    end

    chk(bad_half == 0, "R4 sck high phase", bad_half, 0);
    chk(bad_mosi == 0, "R4 mosi hold", bad_mosi, 0);
    chk(bad_idle == 0, "R4 sck idle low", bad_idle, 0);
    chk(bad_busy == 0, "R8 busy vs cs_n", bad_busy, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule